// File: doc/BRIEF.md
# 100 Mbit/s 4B5B Receive Symbol Decoder

This block sits between a descrambler and a media-independent receive interface. Every clock it may take one aligned 5-bit code group, marked by a valid strobe. It translates the group into a 4-bit data nibble and frames the nibble stream with a data-valid and an error flag. The start delimiter pair (J then K) becomes two `0x5` nibbles, which are the first two preamble nibbles that the MAC sees. The end delimiter pair (T then R) becomes two `0x0` nibbles with data-valid already low.

A one-symbol look-ahead register holds the current group while the next one arrives. Each delimiter pair is therefore known before anything is emitted for its first symbol. The delay is a fixed two valid edges. Faults in the start delimiter, faults in the end delimiter and illegal code groups each raise the error output while the affected nibble is presented. Each class also sets its own sticky status bit, which stays set until a management clear strobe. A bypass input turns the decoder off: raw 5-bit groups then pass straight to the output.

The frame state machine has five states:
- `ST_IDLE`: outside a frame.
- `ST_SSD_K`: emitting the K substitute.
- `ST_BODY`: inside a frame.
- `ST_BAD_K`: the K of a misplaced J/K pair.
- `ST_ESD_R`: emitting the R substitute.

Its transitions are:
- `ST_IDLE`→`ST_SSD_K` on J with K next.
- `ST_SSD_K`→`ST_BODY` always.
- `ST_BODY`→`ST_ESD_R` on T with R next.
- `ST_BODY`→`ST_BAD_K` on J with K next.
- `ST_BAD_K`→`ST_BODY` always.
- `ST_BODY`→`ST_IDLE` on idle, or on T without R.
- `ST_ESD_R`→`ST_IDLE` always.
- Any state→`ST_IDLE` while bypass is set.

Top module: `rx_symbol_decoder`

## Requirements
- R1: In normal mode, a code group inside a frame is output as `rx_word[3:0]`, with `rx_word[4]`=0, `rx_dv`=1 and `rx_er`=0. The mapping is: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R2: Outside a frame, J (11000) immediately followed by K (10001) is output as two nibbles `0x5`, and `rx_dv` rises with the first of them.
- R3: Inside a frame, T (01101) immediately followed by R (00111) is output as two nibbles `0x0` with `rx_dv`=0 and `rx_er`=0, and the frame then ends.
- R4: Inside a frame, any group that is not data, J, T or idle is a codeword error. This includes a lone K, a lone R and undefined values. The group is output as `0x0` with `rx_dv`=1 and `rx_er`=1, it sets `stat_cwrd`, and the frame continues.
- R5: A J not followed by K is a start-delimiter error. So is a J/K pair inside a frame. Each such symbol is output as `0x0` with `rx_er`=1 (with `rx_dv` 0 outside a frame and 1 inside), and it sets `stat_ssd`.
- R6: Inside a frame, idle (11111), or a T not followed by R, is an end-delimiter error. That symbol is output as `0x0` with `rx_dv`=1 and `rx_er`=1, it sets `stat_esd`, and the frame ends.
- R7: Outside a frame, idle and stray groups are output as `0x0` with `rx_dv`=0 and `rx_er`=0.
- R8: The output for a group appears after the second valid edge counted from the edge that accepted it. While `sym_valid` is low, the outputs hold.
- R9: Status bits stay set until `stat_clear`. When a clear and a new error fall on the same edge, the bit stays set.
- R10: With `bypass` set, the held raw group is output on `rx_word[4:0]` with `rx_dv`=1 and `rx_er`=0. There is no substitution and no status is set, and the frame state returns to idle.
- R11: Reset drives all outputs and status bits to 0 and returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A code group is present on `sym_in` |
| sym_in | input | 5 | Aligned code group from the descrambler |
| bypass | input | 1 | Pass raw groups without decoding |
| stat_clear | input | 1 | Clears the sticky status bits |
| rx_word | output | 5 | Nibble in bits 3:0; raw group in bypass |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the presented nibble |
| stat_ssd | output | 1 | Sticky start-delimiter error |
| stat_esd | output | 1 | Sticky end-delimiter error |
| stat_cwrd | output | 1 | Sticky codeword error |

## Verification
A wrong frame state shows at the ports within two valid edges. A decoder stuck outside a frame drops `rx_dv` on the first data nibble. One stuck inside a frame raises `rx_dv` on stray symbols after an end delimiter. A lost look-ahead symbol shifts every nibble by one edge, which the latency-exact vector walk exposes on the first entry after a delimiter. Sticky-bit faults show on the edge after a clear or after an error.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;

    localparam int SYM_W   = 5;
    localparam int NIB_W   = 4;
    localparam int N_FLAGS = 3;
    localparam int FLAG_SSD  = 0;
    localparam int FLAG_ESD  = 1;
    localparam int FLAG_CWRD = 2;

    localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

    localparam logic [NIB_W-1:0] NIB_SSD = 4'h5;
    localparam logic [NIB_W-1:0] NIB_ESD = 4'h0;
    localparam logic [NIB_W-1:0] NIB_ERR = 4'h0;

    typedef enum logic [2:0] {
        SK_DATA,
        SK_IDLE,
        SK_J,
        SK_K,
        SK_T,
        SK_R,
        SK_BAD
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e        kind;
        logic [NIB_W-1:0] nib;
    } sym_class_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSD_K,
        ST_BODY,
        ST_BAD_K,
        ST_ESD_R
    } frame_st_e;

    function automatic sym_class_t classify(input logic [SYM_W-1:0] s);
        sym_class_t c;
        c.kind = SK_DATA;
        c.nib  = '0;
        case (s)
            5'b11110: c.nib = 4'h0;
            5'b01001: c.nib = 4'h1;
            5'b10100: c.nib = 4'h2;
            5'b10101: c.nib = 4'h3;
            5'b01010: c.nib = 4'h4;
            5'b01011: c.nib = 4'h5;
            5'b01110: c.nib = 4'h6;
            5'b01111: c.nib = 4'h7;
            5'b10010: c.nib = 4'h8;
            5'b10011: c.nib = 4'h9;
            5'b10110: c.nib = 4'hA;
            5'b10111: c.nib = 4'hB;
            5'b11010: c.nib = 4'hC;
            5'b11011: c.nib = 4'hD;
            5'b11100: c.nib = 4'hE;
            5'b11101: c.nib = 4'hF;
            CG_IDLE:  c.kind = SK_IDLE;
            CG_J:     c.kind = SK_J;
            CG_K:     c.kind = SK_K;
            CG_T:     c.kind = SK_T;
            CG_R:     c.kind = SK_R;
            default:  c.kind = SK_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rx4b5b_lookahead.sv
module rx4b5b_lookahead
    import rx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] held_raw,
    output sym_class_t       held_cls,
    output sym_class_t       next_cls
);

    // One-group hold register: the held group is decided while the next
    // group, still on the input, serves as the look-ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_raw <= CG_IDLE;
        end else if (sym_valid) begin
            held_raw <= sym_in;
        end
    end

    always_comb begin
        held_cls = classify(held_raw);
        next_cls = classify(sym_in);
    end

endmodule

// File: rtl/rx4b5b_frame_fsm.sv
module rx4b5b_frame_fsm
    import rx4b5b_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               bypass,
    input  logic [SYM_W-1:0]   held_raw,
    input  sym_class_t         held_cls,
    input  sym_class_t         next_cls,
    output logic [SYM_W-1:0]   rx_word,
    output logic               rx_dv,
    output logic               rx_er,
    output logic [N_FLAGS-1:0] flag_set
);

    frame_st_e        state_q, state_d;
    logic [SYM_W-1:0] word_d;
    logic             dv_d;
    logic             er_d;
    logic [N_FLAGS-1:0] raise;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (adv) begin
            state_q <= state_d;
        end
    end

    // Decision for the held group, using the next group as look-ahead
    always_comb begin
        state_d = state_q;
        word_d  = '0;
        dv_d    = 1'b0;
        er_d    = 1'b0;
        raise   = '0;
        if (bypass) begin
            state_d = ST_IDLE;
            word_d  = held_raw;
            dv_d    = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (held_cls.kind == SK_J && next_cls.kind == SK_K) begin
                        word_d  = {1'b0, NIB_SSD};
                        dv_d    = 1'b1;
                        state_d = ST_SSD_K;
                    end else if (held_cls.kind == SK_J) begin
                        er_d            = 1'b1;
                        raise[FLAG_SSD] = 1'b1;
                    end
                end
                ST_SSD_K: begin
                    word_d  = {1'b0, NIB_SSD};
                    dv_d    = 1'b1;
                    state_d = ST_BODY;
                end
                ST_BODY: begin
                    dv_d = 1'b1;
                    unique case (held_cls.kind)
                        SK_DATA: begin
                            word_d = {1'b0, held_cls.nib};
                        end
                        SK_T: begin
                            if (next_cls.kind == SK_R) begin
                                word_d  = {1'b0, NIB_ESD};
                                dv_d    = 1'b0;
                                state_d = ST_ESD_R;
                            end else begin
                                word_d          = {1'b0, NIB_ERR};
                                er_d            = 1'b1;
                                raise[FLAG_ESD] = 1'b1;
                                state_d         = ST_IDLE;
                            end
                        end
                        SK_IDLE: begin
                            word_d          = {1'b0, NIB_ERR};
                            er_d            = 1'b1;
                            raise[FLAG_ESD] = 1'b1;
                            state_d         = ST_IDLE;
                        end
                        SK_J: begin
                            word_d          = {1'b0, NIB_ERR};
                            er_d            = 1'b1;
                            raise[FLAG_SSD] = 1'b1;
                            if (next_cls.kind == SK_K) begin
                                state_d = ST_BAD_K;
                            end
                        end
                        default: begin
                            word_d           = {1'b0, NIB_ERR};
                            er_d             = 1'b1;
                            raise[FLAG_CWRD] = 1'b1;
                        end
                    endcase
                end
                ST_BAD_K: begin
                    word_d          = {1'b0, NIB_ERR};
                    dv_d            = 1'b1;
                    er_d            = 1'b1;
                    raise[FLAG_SSD] = 1'b1;
                    state_d         = ST_BODY;
                end
                ST_ESD_R: begin
                    word_d  = {1'b0, NIB_ESD};
                    state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    assign flag_set = adv ? raise : '0;

    // Registered receive outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            rx_dv   <= 1'b0;
            rx_er   <= 1'b0;
        end else if (adv) begin
            rx_word <= word_d;
            rx_dv   <= dv_d;
            rx_er   <= er_d;
        end
    end

endmodule

// File: rtl/rx4b5b_status_flags.sv
module rx4b5b_status_flags
    import rx4b5b_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [N_FLAGS-1:0] set,
    output logic [N_FLAGS-1:0] flags
);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= (clear ? 1'b0 : flags[i]) | set[i];
            end
        end
    end

endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
    import rx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             bypass,
    input  logic             stat_clear,
    output logic [SYM_W-1:0] rx_word,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             stat_ssd,
    output logic             stat_esd,
    output logic             stat_cwrd
);

    logic [SYM_W-1:0]   held_raw;
    sym_class_t         held_cls;
    sym_class_t         next_cls;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flags;

    rx4b5b_lookahead u_look (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .held_raw  (held_raw),
        .held_cls  (held_cls),
        .next_cls  (next_cls)
    );

    rx4b5b_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (sym_valid),
        .bypass   (bypass),
        .held_raw (held_raw),
        .held_cls (held_cls),
        .next_cls (next_cls),
        .rx_word  (rx_word),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .flag_set (flag_set)
    );

    rx4b5b_status_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (stat_clear),
        .set   (flag_set),
        .flags (flags)
    );

    assign stat_ssd  = flags[FLAG_SSD];
    assign stat_esd  = flags[FLAG_ESD];
    assign stat_cwrd = flags[FLAG_CWRD];

endmodule

// File: rtl/rx_symbol_decoder_checker.sv
module rx_symbol_decoder_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic [4:0] sym_in,
    input logic       bypass,
    input logic       stat_clear,
    input logic [4:0] rx_word,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       stat_ssd,
    input logic       stat_esd,
    input logic       stat_cwrd
);

    AST_NORMAL_NIBBLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sym_valid) && !$past(bypass) |-> !rx_word[4]); // R1

    AST_DV_RISES_WITH_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) && !$past(bypass) |-> rx_word == 5'h05); // R2

    AST_ERR_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sym_valid) && rx_er |-> (stat_ssd || stat_esd || stat_cwrd)); // R4

    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(rx_word) && $stable(rx_dv) && $stable(rx_er)); // R8

    AST_SSD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ssd && !stat_clear |=> stat_ssd); // R9

    AST_ESD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_esd && !stat_clear |=> stat_esd); // R9

    AST_CWRD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_cwrd && !stat_clear |=> stat_cwrd); // R9

    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && bypass |=> rx_dv && !rx_er); // R10

    AST_BYPASS_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && bypass && !stat_ssd |=> !stat_ssd); // R10

endmodule

bind rx_symbol_decoder rx_symbol_decoder_checker u_chk (.*);

// File: tb/rx_symbol_decoder_bench.sv
module rx_symbol_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [4:0] sym_in = 5'b11111;
    logic       bypass = 1'b0;
    logic       stat_clear = 1'b0;
    logic [4:0] rx_word;
    logic       rx_dv;
    logic       rx_er;
    logic       stat_ssd;
    logic       stat_esd;
    logic       stat_cwrd;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_symbol_decoder u_rx_symbol_decoder (.*);

    localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001;
    localparam logic [4:0] T_ = 5'b01101, R_ = 5'b00111;
    localparam logic [4:0] DCODE [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
        5'b01010, 5'b01011, 5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110,
        5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

    // {req, symbol, expected word, expected dv, expected er}
    localparam int NV = 36;
    localparam logic [15:0] VEC [NV] = '{
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd2, J_, 5'h05, 1'b1, 1'b0},   // R2
        {4'd2, K_, 5'h05, 1'b1, 1'b0},
        {4'd1, DCODE[1],  5'h01, 1'b1, 1'b0},   // R1
        {4'd1, DCODE[10], 5'h0A, 1'b1, 1'b0},
        {4'd1, DCODE[15], 5'h0F, 1'b1, 1'b0},
        {4'd1, DCODE[0],  5'h00, 1'b1, 1'b0},
        {4'd3, T_, 5'h00, 1'b0, 1'b0},   // R3
        {4'd3, R_, 5'h00, 1'b0, 1'b0},
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd2, J_, 5'h05, 1'b1, 1'b0},
        {4'd2, K_, 5'h05, 1'b1, 1'b0},
        {4'd1, DCODE[7], 5'h07, 1'b1, 1'b0},
        {4'd4, 5'b00000, 5'h00, 1'b1, 1'b1},    // R4
        {4'd1, DCODE[3], 5'h03, 1'b1, 1'b0},
        {4'd6, I_, 5'h00, 1'b1, 1'b1},   // R6 premature idle
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd5, J_, 5'h00, 1'b0, 1'b1},   // R5 J without K
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd2, J_, 5'h05, 1'b1, 1'b0},
        {4'd2, K_, 5'h05, 1'b1, 1'b0},
        {4'd1, DCODE[9], 5'h09, 1'b1, 1'b0},
        {4'd6, T_, 5'h00, 1'b1, 1'b1},   // R6 T without R
        {4'd7, DCODE[2], 5'h00, 1'b0, 1'b0},    // R7 stray
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd2, J_, 5'h05, 1'b1, 1'b0},
        {4'd2, K_, 5'h05, 1'b1, 1'b0},
        {4'd1, DCODE[12], 5'h0C, 1'b1, 1'b0},
        {4'd5, J_, 5'h00, 1'b1, 1'b1},   // R5 J/K inside frame
        {4'd5, K_, 5'h00, 1'b1, 1'b1},
        {4'd1, DCODE[5], 5'h05, 1'b1, 1'b0},
        {4'd3, T_, 5'h00, 1'b0, 1'b0},
        {4'd3, R_, 5'h00, 1'b0, 1'b0},
        {4'd7, I_, 5'h00, 1'b0, 1'b0},
        {4'd7, I_, 5'h00, 1'b0, 1'b0}
    };

    // two-deep queue of pending expectations (latency of two valid edges, R8)
    logic       p_chk [2];
    logic [4:0] p_w   [2];
    logic       p_dv  [2];
    logic       p_er  [2];
    int         p_req [2];

    task automatic check_bit(input int req, input string what, input logic [4:0] act,
                             input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic pend_reset();
        for (int k = 0; k < 2; k++) begin
            p_chk[k] = 1'b0; p_w[k] = '0; p_dv[k] = 1'b0; p_er[k] = 1'b0; p_req[k] = 0;
        end
    endtask

    task automatic step(input logic [4:0] s, input logic byp, input logic clr,
                        input logic chk, input logic [4:0] w, input logic dv,
                        input logic er, input int req);
        @(negedge clk);
        if (p_chk[1]) begin
            checks++;
            if (rx_word !== p_w[1] || rx_dv !== p_dv[1] || rx_er !== p_er[1]) begin
                errors++;
                $display("FAIL R%0d word/dv/er actual=%h/%b/%b expected=%h/%b/%b at %0t",
                         p_req[1], rx_word, rx_dv, rx_er, p_w[1], p_dv[1], p_er[1], $time);
            end
        end
        p_chk[1] = p_chk[0]; p_w[1] = p_w[0]; p_dv[1] = p_dv[0];
        p_er[1] = p_er[0]; p_req[1] = p_req[0];
        p_chk[0] = chk; p_w[0] = w; p_dv[0] = dv; p_er[0] = er; p_req[0] = req;
        sym_in = s; bypass = byp; stat_clear = clr; sym_valid = 1'b1;
    endtask

    task automatic flush(input logic byp);
        step(I_, byp, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        step(I_, byp, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
    endtask

    task automatic pulse_clear();
        @(negedge clk); stat_clear = 1'b1;
        @(negedge clk); stat_clear = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [4:0] hold_w;
        logic       hold_dv;
        pend_reset();
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit(11, "rx_word after reset", rx_word, 5'h00);
        check_bit(11, "dv/er after reset", {3'b0, rx_dv, rx_er}, 5'h00);
        check_bit(11, "status after reset", {2'b0, stat_ssd, stat_esd, stat_cwrd}, 5'h00);
        rst_n = 1'b1;

        // vector walk: R1 R2 R3 R4 R5 R6 R7, exact latency R8
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:7], 1'b0, 1'b0, 1'b1, VEC[i][6:2], VEC[i][1], VEC[i][0],
                 int'(VEC[i][15:12]));
        end
        flush(1'b0);
        check_bit(5, "stat_ssd after SSD faults", {4'b0, stat_ssd}, 5'h01);   // R5
        check_bit(6, "stat_esd after ESD faults", {4'b0, stat_esd}, 5'h01);   // R6
        check_bit(4, "stat_cwrd after bad code", {4'b0, stat_cwrd}, 5'h01);   // R4

        // R9: clear empties all bits, which then stay clear
        pulse_clear();
        @(negedge clk);
        check_bit(9, "status after clear", {2'b0, stat_ssd, stat_esd, stat_cwrd}, 5'h00);

        // R9: set wins over clear on the same edge
        step(J_, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b1, 5);
        step(I_, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 0);
        step(I_, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        check_bit(9, "stat_ssd set despite clear", {4'b0, stat_ssd}, 5'h01);
        flush(1'b0);

        // R1: all sixteen data groups
        pulse_clear();
        step(J_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(K_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        for (int n = 0; n < 16; n++) begin
            step(DCODE[n], 1'b0, 1'b0, 1'b1, 5'(n), 1'b1, 1'b0, 1);
        end
        step(T_, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 3);
        step(R_, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 3);
        flush(1'b0);
        check_bit(1, "no status after clean frame", {2'b0, stat_ssd, stat_esd, stat_cwrd}, 5'h00);

        // R8: outputs hold while sym_valid is low in mid-frame
        step(J_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(K_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(DCODE[6], 1'b0, 1'b0, 1'b1, 5'h06, 1'b1, 1'b0, 8);
        @(negedge clk);
        sym_valid = 1'b0;
        hold_w = rx_word; hold_dv = rx_dv;
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            check_bit(8, "word held during gap", rx_word, hold_w);
            check_bit(8, "dv held during gap", {4'b0, rx_dv}, {4'b0, hold_dv});
        end
        step(DCODE[11], 1'b0, 1'b0, 1'b1, 5'h0B, 1'b1, 1'b0, 8);
        step(T_, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 3);
        step(R_, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 3);
        flush(1'b0);

        // R10: bypass passes raw groups, no substitution, no status
        step(I_, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        step(J_, 1'b1, 1'b0, 1'b1, J_, 1'b1, 1'b0, 10);
        step(K_, 1'b1, 1'b0, 1'b1, K_, 1'b1, 1'b0, 10);
        step(T_, 1'b1, 1'b0, 1'b1, T_, 1'b1, 1'b0, 10);
        step(R_, 1'b1, 1'b0, 1'b1, R_, 1'b1, 1'b0, 10);
        step(5'b00000, 1'b1, 1'b0, 1'b1, 5'b00000, 1'b1, 1'b0, 10);
        step(DCODE[5], 1'b1, 1'b0, 1'b1, DCODE[5], 1'b1, 1'b0, 10);
        flush(1'b1);
        flush(1'b0);
        check_bit(10, "no status in bypass", {2'b0, stat_ssd, stat_esd, stat_cwrd}, 5'h00);

        // R10: bypass mid-frame drops the frame state to idle
        step(J_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(K_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(DCODE[1], 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        step(DCODE[2], 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 10);
        step(DCODE[3], 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 10);
        flush(1'b0);

        // R11: reset in mid-frame returns to idle
        step(J_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(K_, 1'b0, 1'b0, 1'b1, 5'h05, 1'b1, 1'b0, 2);
        step(DCODE[4], 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        step(5'b00000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        sym_valid = 1'b0;
        pend_reset();
        @(negedge clk);
        check_bit(11, "outputs in reset", {2'b0, rx_dv, rx_er, rx_word[0]}, 5'h00);
        check_bit(11, "status in reset", {2'b0, stat_ssd, stat_esd, stat_cwrd}, 5'h00);
        rst_n = 1'b1;
        step(DCODE[8], 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 11);
        step(DCODE[9], 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 1'b0, 11);
        flush(1'b0);
        flush(1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule